// File: doc/BRIEF.md
# Multi-Mode 16-bit PWM Timer

A 16-bit timer/counter with two compare channels. A 4-bit mode field selects one of sixteen behaviours. Each mode fixes four things: how the count moves (single-slope up, clear-on-match, or up/down), where the wrap limit comes from, when newly written compare values take effect, and which count value sets the overflow flag. The counter moves only on cycles where the prescaled `tick` input is high. Each channel drives a registered PWM output and a one-cycle match strobe.

Software reaches the compare registers and the capture register through one shared data bus with three single-cycle write strobes. Each compare channel keeps a shadow copy of the written value. The active copy, which the match logic uses, is reloaded from the shadow at the update point of the current mode. The block carries no streaming data. There is no valid/ready handshake and nothing can apply back-pressure: a write strobe is taken on the cycle it is high, and every output is a plain registered status or waveform pin.

The terms used below are defined here. BOTTOM is count 0x0000. MAX is count 0xFFFF. TOP is the wrap limit of the current mode. A "tick" is a clock edge at which `tick` is high and the mode is not 13. An event "at X" means a tick whose starting count equals X, and its effect is visible from the next cycle on.

Top module: `pwm_timer16`

## Requirements
- R1: After a synchronous reset, the outputs are `count`=0, `pwm_a`=`pwm_b`=0, `match_a`=`match_b`=0 and `ovf_flag`=0. All compare and capture registers are also 0.
- R2: `count` changes only after a clock edge at which `tick` is high.
- R3: In mode 0, `count` increments by one per tick and wraps from 0xFFFF to 0. In this mode `ovf_flag` sets at MAX and each PWM output toggles on its compare match.
- R4: In modes 4 and 12, `count` returns to 0 after the tick at which it equals TOP, and otherwise increments. In these modes `ovf_flag` sets only at MAX and each PWM output toggles on its compare match.
- R5: In modes 5, 6, 7, 14 and 15, `count` runs from 0 up to TOP and restarts at 0. A count already above TOP also restarts at 0. TOP is 0x00FF in mode 5, 0x01FF in mode 6 and 0x03FF in mode 7. `ovf_flag` sets at TOP. A PWM output is set at BOTTOM and cleared on its match, and the match wins when both occur on the same tick.
- R6: In modes 1, 2, 3, 8, 9, 10 and 11, `count` runs 0,1,…,TOP,TOP−1,…,1,0,1,…, so each end value lasts exactly one tick. TOP is 0x00FF in mode 1, 0x01FF in mode 2 and 0x03FF in mode 3. `ovf_flag` sets at BOTTOM. A PWM output clears on a match while counting up (the match at TOP counts as up) and sets on a match while counting down.
- R7: The active compare value follows the shadow immediately in modes 0, 4, 12 and 13: a write is active on the next cycle. In modes 1, 2, 3, 10 and 11 the active value loads from the shadow at TOP. In modes 5–9, 14 and 15 it loads from the shadow at BOTTOM.
- R8: `match_a`/`match_b` are high for exactly one clock, the one after a tick whose count equals that channel's active compare value.
- R9: In mode 13, `count`, the PWM outputs and `ovf_flag` do not change, and no match strobe fires.
- R10: Writing `ovf_clr`=1 clears `ovf_flag` on the next cycle. A hardware set on the same cycle wins and leaves the flag at 1.
- R11: TOP is the capture register in modes 8, 10, 12 and 14, and the active compare A value in modes 4, 9, 11 and 15. A capture-register write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled count enable |
| mode | input | 4 | Waveform mode select (0–15) |
| wr_data | input | 16 | Shared register write data |
| wr_cmp_a | input | 1 | Write strobe, compare A shadow |
| wr_cmp_b | input | 1 | Write strobe, compare B shadow |
| wr_capt | input | 1 | Write strobe, capture/TOP register |
| ovf_clr | input | 1 | Clears the overflow flag when high |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Waveform output, channel A |
| pwm_b | output | 1 | Waveform output, channel B |
| match_a | output | 1 | Compare match strobe, channel A |
| match_b | output | 1 | Compare match strobe, channel B |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The embedded properties check, on every cycle, the local rules: that the count holds without a tick, the step and the clear in single-slope modes, the turn at TOP in the up/down modes, immediate compare loading, active-value stability between update points, the overflow-flag set/clear priority and the mode-13 freeze. Other behaviour shows only over whole periods, and only the bench's scenarios can show it: the exact TOP per mode, deferred compare writes landing at the right end of the period, PWM duty and polarity on both slopes, and overflow timing per mode. The bench runs a cycle-level arithmetic model of every one of the 16 modes against the outputs.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [2:0] {K_NORMAL, K_CTC, K_FAST, K_DUAL, K_HOLD} kind_e;
  typedef enum logic [2:0] {T_FULL, T_8, T_9, T_10, T_CMPA, T_CAPT} topsrc_e;
  typedef enum logic [1:0] {U_IMM, U_TOP, U_BOT} upd_e;
  typedef enum logic [1:0] {F_MAX, F_TOP, F_BOT} flag_e;

  typedef struct packed {
    kind_e   kind;
    topsrc_e src;
    upd_e    upd;
    flag_e   flg;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    case (m)
      4'd0:    c = '{K_NORMAL, T_FULL, U_IMM, F_MAX};
      4'd1:    c = '{K_DUAL,   T_8,    U_TOP, F_BOT};
      4'd2:    c = '{K_DUAL,   T_9,    U_TOP, F_BOT};
      4'd3:    c = '{K_DUAL,   T_10,   U_TOP, F_BOT};
      4'd4:    c = '{K_CTC,    T_CMPA, U_IMM, F_MAX};
      4'd5:    c = '{K_FAST,   T_8,    U_BOT, F_TOP};
      4'd6:    c = '{K_FAST,   T_9,    U_BOT, F_TOP};
      4'd7:    c = '{K_FAST,   T_10,   U_BOT, F_TOP};
      4'd8:    c = '{K_DUAL,   T_CAPT, U_BOT, F_BOT};
      4'd9:    c = '{K_DUAL,   T_CMPA, U_BOT, F_BOT};
      4'd10:   c = '{K_DUAL,   T_CAPT, U_TOP, F_BOT};
      4'd11:   c = '{K_DUAL,   T_CMPA, U_TOP, F_BOT};
      4'd12:   c = '{K_CTC,    T_CAPT, U_IMM, F_MAX};
      4'd14:   c = '{K_FAST,   T_CAPT, U_BOT, F_TOP};
      4'd15:   c = '{K_FAST,   T_CMPA, U_BOT, F_TOP};
      default: c = '{K_HOLD,   T_FULL, U_IMM, F_MAX};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/timer_mode_decode.sv
module timer_mode_decode import pwm_timer_pkg::*; (
  input  logic [3:0] mode,
  output kind_e      kind,
  output topsrc_e    src,
  output upd_e       upd,
  output flag_e      flg
);
  mode_cfg_t cfg;

  always_comb begin
    cfg  = decode_mode(mode);
    kind = cfg.kind;
    src  = cfg.src;
    upd  = cfg.upd;
    flg  = cfg.flg;
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter import pwm_timer_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         at_top,
  output logic         at_bot,
  output logic         at_max
);
  logic [W-1:0] nxt;
  logic         nxt_up;

  assign at_top = tick && (count == top_val);
  assign at_bot = tick && (count == '0);
  assign at_max = tick && (count == '1);

  always_comb begin
    nxt    = count;
    nxt_up = dir_up;
    if (tick) begin
      case (kind)
        K_NORMAL: begin nxt = count + 1'b1; nxt_up = 1'b1; end
        K_CTC: begin
          nxt    = (count == top_val) ? '0 : count + 1'b1;
          nxt_up = 1'b1;
        end
        K_FAST: begin
          nxt    = (count >= top_val) ? '0 : count + 1'b1;
          nxt_up = 1'b1;
        end
        K_DUAL: begin
          if (dir_up) begin
            if (count >= top_val) begin
              nxt_up = 1'b0;
              nxt    = (count == '0) ? '0 : count - 1'b1;
            end else begin
              nxt = count + 1'b1;
            end
          end else if (count == '0) begin
            nxt_up = 1'b1;
            nxt    = (top_val == '0) ? '0 : W'(1);
          end else begin
            nxt = count - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else begin
      count  <= nxt;
      dir_up <= nxt_up;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count)); // R2
  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && kind == K_NORMAL) |=> count == W'($past(count) + 1'b1)); // R3
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (tick && kind == K_CTC && count == top_val) |=> count == '0); // R4
  AST_FAST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (tick && kind == K_FAST && count >= top_val) |=> count == '0); // R5
  AST_DUAL_TURN: assert property (@(posedge clk) disable iff (rst)
    (tick && kind == K_DUAL && dir_up && count >= top_val && count != '0)
      |=> (!dir_up && count == W'($past(count) - 1'b1))); // R6
endmodule

// File: rtl/timer_cmp_unit.sv
module timer_cmp_unit import pwm_timer_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  kind_e        kind,
  input  upd_e         upd,
  input  logic         dir_up,
  input  logic         at_top,
  input  logic         at_bot,
  input  logic [W-1:0] count,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] act,
  output logic         match,
  output logic         pwm
);
  logic [W-1:0] shadow_q;
  logic         hit;
  logic         upd_ev;

  assign hit = tick && (count == act);

  always_comb begin
    case (upd)
      U_TOP:   upd_ev = at_top;
      U_BOT:   upd_ev = at_bot;
      default: upd_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act      <= '0;
      match    <= 1'b0;
      pwm      <= 1'b0;
    end else begin
      match <= hit;
      if (wr_en) shadow_q <= wr_data;
      if (upd == U_IMM) act <= wr_en ? wr_data : shadow_q;
      else if (upd_ev)  act <= shadow_q;
      case (kind)
        K_FAST: begin
          if (hit)         pwm <= 1'b0;
          else if (at_bot) pwm <= 1'b1;
        end
        K_DUAL:         if (hit) pwm <= !dir_up;
        K_NORMAL, K_CTC: if (hit) pwm <= !pwm;
        default: ;
      endcase
    end
  end

  AST_MATCH_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    match |-> $past(tick)); // R8
  AST_IMM_TAKES: assert property (@(posedge clk) disable iff (rst)
    (upd == U_IMM && wr_en) |=> act == $past(wr_data)); // R7
  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (upd != U_IMM && !upd_ev) |=> $stable(act)); // R7
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16 import pwm_timer_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [3:0]   mode,
  input  logic [W-1:0] wr_data,
  input  logic         wr_cmp_a,
  input  logic         wr_cmp_b,
  input  logic         wr_capt,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         match_a,
  output logic         match_b,
  output logic         ovf_flag
);
  localparam int NCH = 2;
  localparam logic [W-1:0] TOP8  = W'(255);
  localparam logic [W-1:0] TOP9  = W'(511);
  localparam logic [W-1:0] TOP10 = W'(1023);

  kind_e   kind;
  topsrc_e src;
  upd_e    upd;
  flag_e   flg;
  logic         tick_eff, dir_up, at_top, at_bot, at_max, ovf_set;
  logic [W-1:0] top_val, capt_q;
  logic [NCH-1:0]        wr_v, match_v, pwm_v;
  logic [NCH-1:0][W-1:0] act_v;

  timer_mode_decode u_dec (.mode(mode), .kind(kind), .src(src), .upd(upd), .flg(flg));

  assign tick_eff = tick && (kind != K_HOLD);

  always_comb begin
    case (src)
      T_8:     top_val = TOP8;
      T_9:     top_val = TOP9;
      T_10:    top_val = TOP10;
      T_CMPA:  top_val = act_v[0];
      T_CAPT:  top_val = capt_q;
      default: top_val = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          capt_q <= '0;
    else if (wr_capt) capt_q <= wr_data;
  end

  timer_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_eff), .kind(kind), .top_val(top_val),
    .count(count), .dir_up(dir_up), .at_top(at_top), .at_bot(at_bot), .at_max(at_max)
  );

  assign wr_v = {wr_cmp_b, wr_cmp_a};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    timer_cmp_unit #(.W(W)) u_cmp (
      .clk(clk), .rst(rst), .tick(tick_eff), .kind(kind), .upd(upd), .dir_up(dir_up),
      .at_top(at_top), .at_bot(at_bot), .count(count), .wr_en(wr_v[ch]),
      .wr_data(wr_data), .act(act_v[ch]), .match(match_v[ch]), .pwm(pwm_v[ch])
    );
  end

  assign pwm_a   = pwm_v[0];
  assign pwm_b   = pwm_v[1];
  assign match_a = match_v[0];
  assign match_b = match_v[1];

  always_comb begin
    case (flg)
      F_TOP:   ovf_set = at_top;
      F_BOT:   ovf_set = at_bot;
      default: ovf_set = at_max;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (ovf_set) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ovf_set |=> ovf_flag); // R10
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !ovf_set) |=> !ovf_flag); // R10
  AST_RESERVED_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd13) |=> ($stable(count) && $stable(pwm_a) && $stable(pwm_b)
                         && !match_a && !match_b)); // R9
endmodule

// File: tb/tb_pwm_timer16.sv
module tb_pwm_timer16;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, tick = 1'b0, wr_a = 1'b0, wr_b = 1'b0, wr_c = 1'b0, ovf_clr = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        pwm_a, pwm_b, match_a, match_b, ovf_flag;

  pwm_timer16 dut (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr_data(wr_data),
    .wr_cmp_a(wr_a), .wr_cmp_b(wr_b), .wr_capt(wr_c), .ovf_clr(ovf_clr),
    .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .match_a(match_a),
    .match_b(match_b), .ovf_flag(ovf_flag)
  );

  int n_vec = 0, n_bad = 0;
  logic chk_on = 1'b0;

  // ---- arithmetic model built from the requirements ----
  // kind: 0 up, 1 clear-on-TOP, 2 single-slope PWM, 3 up/down, 4 frozen
  function automatic int m_kind(input logic [3:0] m);
    if (m == 0) return 0;
    if (m == 4 || m == 12) return 1;
    if ((m >= 5 && m <= 7) || m >= 14) return 2;
    if (m == 13) return 4;
    return 3;
  endfunction
  // update point: 0 immediate, 1 TOP, 2 BOTTOM
  function automatic int m_upd(input logic [3:0] m);
    if (m == 0 || m == 4 || m == 12 || m == 13) return 0;
    if ((m >= 1 && m <= 3) || m == 10 || m == 11) return 1;
    return 2;
  endfunction
  function automatic logic [15:0] m_top(input logic [3:0] m, input logic [15:0] a, input logic [15:0] c);
    case (m)
      1, 5:  return 16'h00FF;
      2, 6:  return 16'h01FF;
      3, 7:  return 16'h03FF;
      4, 9, 11, 15: return a;
      8, 10, 12, 14: return c;
      default: return 16'hFFFF;
    endcase
  endfunction
  function automatic string m_tag(input logic [3:0] m);
    case (m)
      0: return "R3";
      4: return "R4/R11";
      12: return "R4/R11";
      5, 6, 7: return "R5";
      14, 15: return "R5/R11";
      13: return "R9";
      1, 2, 3: return "R6";
      default: return "R6/R11";
    endcase
  endfunction

  logic [15:0] m_cnt, m_bufa, m_bufb, m_acta, m_actb, m_capt, m_tp;
  logic m_up, m_pa, m_pb, m_ma, m_mb, m_ovf;
  logic e_t, e_top, e_bot, e_max, h_a, h_b, u_ev, o_set;
  int   k, up_pt;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0; m_capt = 0;
      m_up = 1; m_pa = 0; m_pb = 0; m_ma = 0; m_mb = 0; m_ovf = 0;
    end else begin
      k = m_kind(mode); up_pt = m_upd(mode);
      e_t   = tick && (k != 4);
      m_tp  = m_top(mode, m_acta, m_capt);
      e_top = e_t && (m_cnt == m_tp);
      e_bot = e_t && (m_cnt == 0);
      e_max = e_t && (m_cnt == 16'hFFFF);
      h_a   = e_t && (m_cnt == m_acta);
      h_b   = e_t && (m_cnt == m_actb);
      u_ev  = (up_pt == 1) ? e_top : (up_pt == 2) ? e_bot : 1'b0;
      if (k == 0 || k == 1) o_set = e_max;
      else if (k == 2) o_set = e_top;
      else if (k == 3) o_set = e_bot;
      else o_set = 1'b0;
      if (k == 2) begin
        if (h_a) m_pa = 0; else if (e_bot) m_pa = 1;
        if (h_b) m_pb = 0; else if (e_bot) m_pb = 1;
      end else if (k == 3) begin
        if (h_a) m_pa = !m_up;
        if (h_b) m_pb = !m_up;
      end else if (k < 2) begin
        if (h_a) m_pa = !m_pa;
        if (h_b) m_pb = !m_pb;
      end
      m_ma = h_a; m_mb = h_b;
      if (o_set) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (up_pt == 0) begin
        m_acta = wr_a ? wr_data : m_bufa;
        m_actb = wr_b ? wr_data : m_bufb;
      end else if (u_ev) begin
        m_acta = m_bufa; m_actb = m_bufb;
      end
      if (wr_a) m_bufa = wr_data;
      if (wr_b) m_bufb = wr_data;
      if (e_t) begin
        if (k == 0) begin m_cnt = m_cnt + 1; m_up = 1; end
        else if (k == 1) begin m_cnt = (m_cnt == m_tp) ? 16'd0 : m_cnt + 1; m_up = 1; end
        else if (k == 2) begin m_cnt = (m_cnt >= m_tp) ? 16'd0 : m_cnt + 1; m_up = 1; end
        else if (m_up) begin
          if (m_cnt >= m_tp) begin m_up = 0; m_cnt = (m_cnt == 0) ? 16'd0 : m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          m_up = 1; m_cnt = (m_tp == 0) ? 16'd0 : 16'd1;
        end else m_cnt = m_cnt - 1;
      end
      if (wr_c) m_capt = wr_data;
    end
  end

  // per-cycle comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (chk_on) begin
      n_vec++;
      if (count !== m_cnt || pwm_a !== m_pa || pwm_b !== m_pb || match_a !== m_ma ||
          match_b !== m_mb || ovf_flag !== m_ovf) begin
        n_bad++;
        if (n_bad <= 20)
          $display("FAIL %s%s%s mode %0d: got cnt=%h pwm=%b%b match=%b%b ovf=%b expected cnt=%h pwm=%b%b match=%b%b ovf=%b",
                   m_tag(mode), (match_a !== m_ma || match_b !== m_mb) ? " R8" : "",
                   (ovf_flag !== m_ovf) ? " R10" : "", mode,
                   count, pwm_a, pwm_b, match_a, match_b, ovf_flag,
                   m_cnt, m_pa, m_pb, m_ma, m_mb, m_ovf);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; mode = 0; tick = 0; ovf_clr = 0; wr_a = 0; wr_b = 0; wr_c = 0;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic put(input int which, input logic [15:0] v);
    @(negedge clk);
    wr_data = v; wr_a = (which == 0); wr_b = (which == 1); wr_c = (which == 2);
    @(negedge clk);
    wr_a = 0; wr_b = 0; wr_c = 0;
  endtask

  task automatic wait_cnt(input logic [15:0] v, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (m_cnt == v) break;
    end
  endtask

  task automatic run_mode(input logic [3:0] md, input logic [15:0] c, input logic [15:0] a,
                          input logic [15:0] b, input int ncyc, input int gap);
    do_reset();
    put(2, c); put(0, a); put(1, b);
    mode = md;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      tick    = (gap == 0) || (i % gap != 0);
      ovf_clr = (i % 53 == 52);
      wr_data = (i == ncyc / 3) ? a - 16'd1 : b + 16'd1;
      wr_a    = (i == ncyc / 3);
      wr_b    = (i == ncyc / 2);
    end
    @(negedge clk);
    tick = 0; ovf_clr = 0; wr_a = 0; wr_b = 0;
  endtask

  int seen;
  logic [15:0] held;

  initial begin
    do_reset();
    chk_on = 1;
    // R1: reset state
    check("R1", count, 0, "count after reset");
    check("R1", {pwm_a, pwm_b, match_a, match_b, ovf_flag}, 0, "outputs after reset");

    // R2: no tick, no movement
    put(0, 16'd40); mode = 5; tick = 1;
    repeat (6) @(negedge clk);
    tick = 0; held = count;
    repeat (8) @(negedge clk);
    check("R2", count, held, "count while tick low");

    // R9: reserved mode freezes
    mode = 13; tick = 1; held = count; seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (match_a || match_b) seen++;
    end
    check("R9", count, held, "count in mode 13");
    check("R9", seen, 0, "strobes in mode 13");

    // R10: set beats clear, then clear works
    do_reset(); mode = 5; tick = 1; ovf_clr = 1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (m_ovf) break;
    end
    check("R10", ovf_flag, 1, "flag on set-with-clear cycle");
    @(negedge clk);
    check("R10", ovf_flag, 0, "flag after clear");
    ovf_clr = 0;

    // R7 / R8: deferred compare write in mode 5
    do_reset(); put(0, 16'd40); put(1, 16'd200); mode = 5; tick = 1;
    wait_cnt(16'd10, 300);
    put(0, 16'd20);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (match_a) seen++;
      if (m_cnt == 16'd30) break;
    end
    check("R7", seen, 0, "match before BOTTOM reload");
    wait_cnt(16'd0, 300);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (match_a) seen++;
      if (m_cnt == 16'd30) break;
    end
    check("R8", seen, 1, "single strobe after reload (R7)");

    // R11: capture register as TOP in mode 12
    do_reset(); put(2, 16'd9); put(0, 16'd4); mode = 12; tick = 1;
    wait_cnt(16'd9, 40);
    @(negedge clk);
    check("R11", count, 0, "count after TOP from capture");

    // sweeps over all modes
    run_mode(4'd0, 16'd9, 16'd100, 16'hFFF0, 66000, 0);
    for (int md = 1; md < 16; md++) begin
      case (md)
        1, 2, 3, 5, 6, 7: run_mode(md[3:0], 16'd9, 16'd40, 16'd200, 2400, 7);
        4:       run_mode(4'd4, 16'd9, 16'd12, 16'd5, 400, 5);
        12:      run_mode(4'd12, 16'd9, 16'd4, 16'd7, 400, 5);
        9, 11, 15: run_mode(md[3:0], 16'd9, 16'd10, 16'd4, 400, 5);
        13:      run_mode(4'd13, 16'd9, 16'd3, 16'd5, 50, 0);
        default: run_mode(md[3:0], 16'd9, 16'd3, 16'd6, 400, 5);
      endcase
    end

    chk_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule